// File: doc/BRIEF.md
# Interrupt Pending-State Latch Bank

This block holds the pending state for a bank of interrupt lines. Each line is set to edge or level behaviour by a per-line configuration input. The block keeps two registers per line. One is a latch that remembers software and edge requests. The other is a sampled copy of the input level. For an edge line the pending state is the latch alone. For a level line it is the latch OR the sampled level. A clear request or an activation therefore cannot hide a level that is still held high.

Two word-wide register ports reach the state. Each 32-bit word covers 32 consecutive interrupt IDs, and word `w` holds IDs `32*w .. 32*w+31`, with bit `n` mapped to ID `32*w+n`. The guest port has the usual set-pending, clear-pending and pending-read behaviour. The save/restore port reads and loads the raw latch bits and the sampled levels directly, so a full context can be captured and put back. A small status register records accesses to words beyond the implemented range. It is write-one-to-clear on the guest port and loaded directly on the save/restore port.

Top module: `pend_latch_bank`

## Requirements
- R1: An edge line (`trig_edge_i` bit = 1) becomes pending at the clock edge where its input is 1 and its previous sampled level is 0. It stays pending after the input falls, until an activation or a clear-pending write hits it.
- R2: A guest set-pending write (`g_sel_i` = 0) sets the latch of every line whose data bit is 1, whatever its trigger type. When a set and an activation of the same line fall in the same cycle, the set wins.
- R3: An activation pulse (`activate_i` bit) or a guest clear-pending write (`g_sel_i` = 1) with a 1 in that bit clears the latch one edge later.
- R4: A guest read of the set-pending or clear-pending view returns the pending state. For a level line (`trig_edge_i` bit = 0) that state is the latch OR the sampled level, so while the input stays high the line reads pending even after a clear-pending write.
- R5: A level line whose input has fallen and whose latch is clear is not pending one edge after the input falls.
- R6: The save/restore latch view (`s_sel_i` = 0) reads the raw latch without the level term. A write loads all 32 latch bits of the word. In the same cycle it overrides any guest set, guest clear, edge or activation on that word.
- R7: The save/restore clear-pending view (`s_sel_i` = 1) reads as zero and ignores writes.
- R8: The save/restore level view (`s_sel_i` = 3) reads the sampled levels. A write loads the sampled-level register for one cycle before the input is sampled again. Bits for IDs 0 to 15 read as zero and ignore writes.
- R9: In the pending, latch and level views, a word index at or above `NUM_IRQ/32` reads as zero and changes no state. A guest access of that kind sets status bit 0, and a save/restore access of that kind sets status bit 1.
- R10: Status (`g_sel_i` = 2 or `s_sel_i` = 2) reads `{30'b0, bit1, bit0}`. A guest write clears the bits written as 1, but a same-cycle event still sets its bit. A save/restore write loads bits 1:0 from the data.
- R11: After reset every latch, every sampled level, every pending output and the status bits are zero. The guest reserved selector (`g_sel_i` = 3) reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_i | input | NUM_IRQ | Interrupt input lines |
| trig_edge_i | input | NUM_IRQ | 1 = edge line, 0 = level line |
| activate_i | input | NUM_IRQ | One-cycle activation pulses |
| g_req_i | input | 1 | Guest port access strobe |
| g_we_i | input | 1 | Guest port write enable |
| g_sel_i | input | 2 | Guest view: 0 set-pend, 1 clear-pend, 2 status, 3 reserved |
| g_word_i | input | WORD_W | Guest word index |
| g_wdata_i | input | 32 | Guest write data |
| g_rdata_o | output | 32 | Guest read data, combinational on current state |
| s_req_i | input | 1 | Save/restore access strobe |
| s_we_i | input | 1 | Save/restore write enable |
| s_sel_i | input | 2 | Save view: 0 latch, 1 clear-pend, 2 status, 3 level |
| s_word_i | input | WORD_W | Save/restore word index |
| s_wdata_i | input | 32 | Save/restore write data |
| s_rdata_o | output | 32 | Save/restore read data, combinational |
| pend_o | output | NUM_IRQ | Pending state of every line |

## Verification
The assertions assume that `trig_edge_i` stays steady while a line is pending, since some properties compare the trigger type across two cycles. They also assume that reads are sampled only while `rst_ni` is high. The bench changes the trigger configuration only while the bank is idle and its latches are cleared. It drives lines, pulses and port strobes on the falling clock edge and holds each request for exactly one rising edge, so every property sees one stable cycle per stimulus. Collisions are created on purpose in single cycles, such as a set with an activation, or a save write against a guest write. These single-cycle collisions exercise the priority claims.

// File: rtl/pend_bank_pkg.sv
package pend_bank_pkg;
    localparam int WORD_BITS = 32;
    localparam int SGI_COUNT = 16;
    localparam int STAT_BITS = 2;

    typedef enum logic [1:0] {
        G_SETPEND = 2'd0,
        G_CLRPEND = 2'd1,
        G_STATUS  = 2'd2,
        G_RSVD    = 2'd3
    } guest_sel_e;

    typedef enum logic [1:0] {
        S_LATCH   = 2'd0,
        S_CLRPEND = 2'd1,
        S_STATUS  = 2'd2,
        S_LEVEL   = 2'd3
    } save_sel_e;
endpackage

// File: rtl/pend_port_dec.sv
module pend_port_dec #(
    parameter int NUM_IRQ = 96,
    parameter int WORD_W  = 5
) (
    input  logic               acc_i,
    input  logic               wr_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic [31:0]        wdata_i,
    output logic               in_range_o,
    output logic               oor_o,
    output logic [NUM_IRQ-1:0] wr_en_o,
    output logic [NUM_IRQ-1:0] wr_bits_o
);
    localparam int NUM_WORDS = NUM_IRQ / pend_bank_pkg::WORD_BITS;

    assign in_range_o = ({1'b0, word_i} < (WORD_W+1)'(NUM_WORDS));
    assign oor_o      = acc_i & ~in_range_o;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit;
        assign hit = acc_i & wr_i & in_range_o & (word_i == WORD_W'(w));
        assign wr_en_o[w*32 +: 32] = {32{hit}};
    end

    assign wr_bits_o = {NUM_WORDS{wdata_i}} & wr_en_o;
endmodule

// File: rtl/pend_core.sv
module pend_core #(
    parameter int NUM_IRQ = 96
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] line_i,
    input  logic [NUM_IRQ-1:0] trig_edge_i,
    input  logic [NUM_IRQ-1:0] act_i,
    input  logic [NUM_IRQ-1:0] g_set_i,
    input  logic [NUM_IRQ-1:0] g_clr_i,
    input  logic [NUM_IRQ-1:0] s_latch_en_i,
    input  logic [NUM_IRQ-1:0] s_latch_bits_i,
    input  logic [NUM_IRQ-1:0] s_lvl_en_i,
    input  logic [NUM_IRQ-1:0] s_lvl_bits_i,
    output logic [NUM_IRQ-1:0] latch_o,
    output logic [NUM_IRQ-1:0] lvl_o,
    output logic [NUM_IRQ-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] latch;
        logic [NUM_IRQ-1:0] lvl;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [NUM_IRQ-1:0] rise_d, set_d, clr_d;

    always_comb begin
        rise_d     = line_i & ~st_q.lvl & trig_edge_i;
        set_d      = rise_d | g_set_i;
        clr_d      = act_i | g_clr_i;
        st_d       = st_q;
        st_d.latch = (st_q.latch & ~clr_d) | set_d;
        st_d.latch = (st_d.latch & ~s_latch_en_i) | (s_latch_bits_i & s_latch_en_i);
        st_d.lvl   = (line_i & ~s_lvl_en_i) | (s_lvl_bits_i & s_lvl_en_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign latch_o = st_q.latch;
    assign lvl_o   = st_q.lvl;
    assign pend_o  = st_q.latch | (st_q.lvl & ~trig_edge_i);

    AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((($past(st_q.latch) & ~$past(act_i | g_clr_i) & ~$past(s_latch_en_i)) & ~st_q.latch) == '0)); // R1

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((($past(g_set_i) & ~$past(s_latch_en_i)) & ~pend_o) == '0)); // R2

    AST_LEVEL_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((($past(line_i) & ~$past(s_lvl_en_i) & ~$past(trig_edge_i) & ~trig_edge_i) & ~pend_o) == '0)); // R4

    AST_LEVEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((($past(~line_i & ~s_lvl_en_i & ~st_q.latch & ~g_set_i & ~s_latch_en_i & ~trig_edge_i)
                   & ~trig_edge_i) & pend_o) == '0)); // R5
endmodule

// File: rtl/pend_status.sv
module pend_status (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                g_evt_i,
    input  logic                                s_evt_i,
    input  logic                                g_w1c_i,
    input  logic [pend_bank_pkg::STAT_BITS-1:0] g_wdata_i,
    input  logic                                s_load_i,
    input  logic [pend_bank_pkg::STAT_BITS-1:0] s_wdata_i,
    output logic [pend_bank_pkg::STAT_BITS-1:0] stat_o
);
    import pend_bank_pkg::*;

    logic [STAT_BITS-1:0] stat_d, stat_q;
    logic [STAT_BITS-1:0] evt_d;

    always_comb begin
        evt_d  = {s_evt_i, g_evt_i};
        stat_d = stat_q;
        if (g_w1c_i) stat_d = stat_d & ~g_wdata_i;
        stat_d = stat_d | evt_d;
        if (s_load_i) stat_d = s_wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) stat_q <= '0;
        else         stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    AST_STAT_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (g_w1c_i && g_wdata_i[0] && !s_load_i && !g_evt_i) |=> !stat_q[0]); // R10

    AST_STAT_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (g_evt_i && !s_load_i) |=> stat_q[0]); // R9
endmodule

// File: rtl/pend_latch_bank.sv
module pend_latch_bank #(
    parameter int NUM_IRQ = 96,
    parameter int WORD_W  = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] line_i,
    input  logic [NUM_IRQ-1:0] trig_edge_i,
    input  logic [NUM_IRQ-1:0] activate_i,
    input  logic               g_req_i,
    input  logic               g_we_i,
    input  logic [1:0]         g_sel_i,
    input  logic [WORD_W-1:0]  g_word_i,
    input  logic [31:0]        g_wdata_i,
    output logic [31:0]        g_rdata_o,
    input  logic               s_req_i,
    input  logic               s_we_i,
    input  logic [1:0]         s_sel_i,
    input  logic [WORD_W-1:0]  s_word_i,
    input  logic [31:0]        s_wdata_i,
    output logic [31:0]        s_rdata_o,
    output logic [NUM_IRQ-1:0] pend_o
);
    import pend_bank_pkg::*;

    localparam int NUM_WORDS = NUM_IRQ / WORD_BITS;
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [NUM_IRQ-1:0] SGI_MASK = {{(NUM_IRQ-SGI_COUNT){1'b0}}, {SGI_COUNT{1'b1}}};

    initial begin
        if (NUM_IRQ < 64 || NUM_IRQ > 1024 || (NUM_IRQ % WORD_BITS) != 0 || NUM_WORDS > (1 << WORD_W))
            $error("pend_latch_bank: unsupported NUM_IRQ/WORD_W");
    end

    guest_sel_e g_sel;
    save_sel_e  s_sel;
    assign g_sel = guest_sel_e'(g_sel_i);
    assign s_sel = save_sel_e'(s_sel_i);

    logic g_acc, s_acc, g_in, s_in, g_oor, s_oor;
    logic [NUM_IRQ-1:0] g_en, g_bits, s_en, s_bits;

    assign g_acc = g_req_i & ((g_sel == G_SETPEND) | (g_sel == G_CLRPEND));
    assign s_acc = s_req_i & ((s_sel == S_LATCH) | (s_sel == S_LEVEL));

    pend_port_dec #(.NUM_IRQ(NUM_IRQ), .WORD_W(WORD_W)) i_gdec (
        .acc_i(g_acc), .wr_i(g_we_i), .word_i(g_word_i), .wdata_i(g_wdata_i),
        .in_range_o(g_in), .oor_o(g_oor), .wr_en_o(g_en), .wr_bits_o(g_bits)
    );

    pend_port_dec #(.NUM_IRQ(NUM_IRQ), .WORD_W(WORD_W)) i_sdec (
        .acc_i(s_acc), .wr_i(s_we_i), .word_i(s_word_i), .wdata_i(s_wdata_i),
        .in_range_o(s_in), .oor_o(s_oor), .wr_en_o(s_en), .wr_bits_o(s_bits)
    );

    logic [NUM_IRQ-1:0] g_set, g_clr, s_latch_en, s_lvl_en;
    assign g_set      = g_bits & {NUM_IRQ{g_sel == G_SETPEND}};
    assign g_clr      = g_bits & {NUM_IRQ{g_sel == G_CLRPEND}};
    assign s_latch_en = s_en & {NUM_IRQ{s_sel == S_LATCH}};
    assign s_lvl_en   = s_en & {NUM_IRQ{s_sel == S_LEVEL}} & ~SGI_MASK;

    logic [NUM_IRQ-1:0] latch, lvl, pend;

    pend_core #(.NUM_IRQ(NUM_IRQ)) i_core (
        .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .trig_edge_i(trig_edge_i),
        .act_i(activate_i), .g_set_i(g_set), .g_clr_i(g_clr),
        .s_latch_en_i(s_latch_en), .s_latch_bits_i(s_bits),
        .s_lvl_en_i(s_lvl_en), .s_lvl_bits_i(s_bits),
        .latch_o(latch), .lvl_o(lvl), .pend_o(pend)
    );

    logic [STAT_BITS-1:0] stat;

    pend_status i_stat (
        .clk_i(clk_i), .rst_ni(rst_ni), .g_evt_i(g_oor), .s_evt_i(s_oor),
        .g_w1c_i(g_req_i & g_we_i & (g_sel == G_STATUS)), .g_wdata_i(g_wdata_i[STAT_BITS-1:0]),
        .s_load_i(s_req_i & s_we_i & (s_sel == S_STATUS)), .s_wdata_i(s_wdata_i[STAT_BITS-1:0]),
        .stat_o(stat)
    );

    logic [NUM_WORDS-1:0][31:0] pend_w, latch_w, lvl_w;
    assign pend_w  = pend;
    assign latch_w = latch;
    assign lvl_w   = lvl & ~SGI_MASK;

    logic [IDX_W-1:0] g_idx, s_idx;
    assign g_idx = g_word_i[IDX_W-1:0];
    assign s_idx = s_word_i[IDX_W-1:0];

    always_comb begin
        g_rdata_o = '0;
        if (g_req_i) begin
            unique case (g_sel)
                G_SETPEND, G_CLRPEND: g_rdata_o = g_in ? pend_w[g_idx] : '0;
                G_STATUS:             g_rdata_o = 32'(stat);
                default:              g_rdata_o = '0;
            endcase
        end
    end

    always_comb begin
        s_rdata_o = '0;
        if (s_req_i) begin
            unique case (s_sel)
                S_LATCH:  s_rdata_o = s_in ? latch_w[s_idx] : '0;
                S_LEVEL:  s_rdata_o = s_in ? lvl_w[s_idx] : '0;
                S_STATUS: s_rdata_o = 32'(stat);
                default:  s_rdata_o = '0;
            endcase
        end
    end

    assign pend_o = pend;

    AST_SAVE_CLR_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_req_i && s_sel_i == 2'd1) |-> (s_rdata_o == '0)); // R7

    AST_OOR_NO_TOUCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (g_req_i && g_we_i && g_sel_i == 2'd0 && !g_in && !s_req_i && activate_i == '0
         && $stable(line_i) && $stable(trig_edge_i) && (line_i & ~lvl) == '0) |=> $stable(pend_o)); // R9
endmodule

// File: tb/test_pend_latch_bank.sv
module test_pend_latch_bank;
    localparam int N = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [N-1:0] line, trig, act;
    logic g_req, g_we, s_req, s_we;
    logic [1:0] g_sel, s_sel;
    logic [4:0] g_word, s_word;
    logic [31:0] g_wd, s_wd, g_rd, s_rd;
    logic [N-1:0] pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pend_latch_bank #(.NUM_IRQ(N), .WORD_W(5)) i_pend_latch_bank (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line), .trig_edge_i(trig), .activate_i(act),
        .g_req_i(g_req), .g_we_i(g_we), .g_sel_i(g_sel), .g_word_i(g_word),
        .g_wdata_i(g_wd), .g_rdata_o(g_rd),
        .s_req_i(s_req), .s_we_i(s_we), .s_sel_i(s_sel), .s_word_i(s_word),
        .s_wdata_i(s_wd), .s_rdata_o(s_rd), .pend_o(pend)
    );

    task automatic chk(input string req, input string what, input logic [31:0] actv, input logic [31:0] expv);
        checks++;
        if (actv !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, actv, expv);
        end
    endtask

    task automatic g_acc(input logic [1:0] sel, input logic [4:0] word, input logic we,
                         input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        g_req = 1'b1; g_we = we; g_sel = sel; g_word = word; g_wd = wd;
        #1 rd = g_rd;
        @(negedge clk);
        g_req = 1'b0; g_we = 1'b0;
        #1;
    endtask

    task automatic s_acc(input logic [1:0] sel, input logic [4:0] word, input logic we,
                         input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_sel = sel; s_word = word; s_wd = wd;
        #1 rd = s_rd;
        @(negedge clk);
        s_req = 1'b0; s_we = 1'b0;
        #1;
    endtask

    task automatic wipe();
        logic [31:0] d;
        line = '0; act = '0;
        for (int w = 0; w < 3; w++) s_acc(2'd0, 5'(w), 1'b1, 32'h0, d);
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R11", "pend low word", pend[31:0], 32'h0);
        chk("R11", "pend high bits", {pend[95:64] | pend[63:32]}, 32'h0);
        g_acc(2'd2, 5'd0, 1'b0, 32'h0, d); chk("R11", "status", d, 32'h0);
        s_acc(2'd3, 5'd1, 1'b0, 32'h0, d); chk("R11", "level word1", d, 32'h0);
        g_acc(2'd3, 5'd0, 1'b0, 32'h0, d); chk("R11", "guest reserved", d, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wipe();
        @(negedge clk) line[40] = 1'b1;
        @(negedge clk) #1 chk("R1", "edge sets", 32'(pend[40]), 32'd1);
        line[40] = 1'b0;
        @(negedge clk) #1 chk("R1", "edge held after fall", 32'(pend[40]), 32'd1);
        g_acc(2'd0, 5'd1, 1'b0, 32'h0, d); chk("R1", "guest read word1", d, 32'h0000_0100);
        g_acc(2'd1, 5'd1, 1'b1, 32'h0000_0100, d); chk("R3", "clear write", 32'(pend[40]), 32'd0);
        @(negedge clk) line[40] = 1'b1;
        @(negedge clk) #1 chk("R1", "second edge", 32'(pend[40]), 32'd1);
        @(negedge clk) act[40] = 1'b1;
        @(negedge clk) act[40] = 1'b0;
        #1 chk("R3", "activation clears edge", 32'(pend[40]), 32'd0);
        line[40] = 1'b0;
    endtask

    task automatic t_set_prio();
        wipe();
        @(negedge clk);
        g_req = 1'b1; g_we = 1'b1; g_sel = 2'd0; g_word = 5'd1; g_wd = 32'h0004_0000;
        act[50] = 1'b1;
        @(negedge clk);
        g_req = 1'b0; g_we = 1'b0; act[50] = 1'b0;
        #1 chk("R2", "set beats activation", 32'(pend[50]), 32'd1);
        @(negedge clk) act[50] = 1'b1;
        @(negedge clk) act[50] = 1'b0;
        #1 chk("R3", "activation alone clears", 32'(pend[50]), 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wipe();
        @(negedge clk) line[70] = 1'b1;
        @(negedge clk) #1 chk("R4", "level high pending", 32'(pend[70]), 32'd1);
        g_acc(2'd0, 5'd2, 1'b0, 32'h0, d); chk("R4", "guest read OR", d, 32'h0000_0040);
        g_acc(2'd1, 5'd2, 1'b1, 32'h0000_0040, d);
        chk("R4", "clear cannot hide level", 32'(pend[70]), 32'd1);
        s_acc(2'd0, 5'd2, 1'b0, 32'h0, d); chk("R6", "raw latch excludes level", d, 32'h0);
        g_acc(2'd0, 5'd2, 1'b1, 32'h0000_0040, d);
        s_acc(2'd0, 5'd2, 1'b0, 32'h0, d); chk("R6", "raw latch after set", d, 32'h0000_0040);
        @(negedge clk) line[70] = 1'b0;
        @(negedge clk) #1 chk("R4", "latch keeps level pending", 32'(pend[70]), 32'd1);
        @(negedge clk) act[70] = 1'b1;
        @(negedge clk) act[70] = 1'b0;
        #1 chk("R3", "activation clears level latch", 32'(pend[70]), 32'd0);
    endtask

    task automatic t_level_drop();
        wipe();
        @(negedge clk) line[74] = 1'b1;
        @(negedge clk) line[74] = 1'b0;
        #1 chk("R4", "level pending while high", 32'(pend[74]), 32'd1);
        @(negedge clk) #1 chk("R5", "level drop not pending", 32'(pend[74]), 32'd0);
    endtask

    task automatic t_save();
        logic [31:0] d;
        wipe();
        s_acc(2'd0, 5'd0, 1'b1, 32'hA5A5_0000, d);
        chk("R6", "latch load", pend[31:0], 32'hA5A5_0000);
        s_acc(2'd1, 5'd0, 1'b0, 32'h0, d); chk("R7", "save clear reads zero", d, 32'h0);
        s_acc(2'd1, 5'd0, 1'b1, 32'hFFFF_FFFF, d);
        chk("R7", "save clear write ignored", pend[31:0], 32'hA5A5_0000);
        @(negedge clk);
        s_req = 1'b1; s_we = 1'b1; s_sel = 2'd0; s_word = 5'd0; s_wd = 32'h0000_0F00;
        g_req = 1'b1; g_we = 1'b1; g_sel = 2'd0; g_word = 5'd0; g_wd = 32'h0000_0001;
        @(negedge clk);
        s_req = 1'b0; s_we = 1'b0; g_req = 1'b0; g_we = 1'b0;
        #1 chk("R6", "save load overrides guest set", pend[31:0], 32'h0000_0F00);
    endtask

    task automatic t_level_view();
        logic [31:0] d;
        wipe();
        @(negedge clk) begin line[5] = 1'b1; line[20] = 1'b1; end
        @(negedge clk);
        s_acc(2'd3, 5'd0, 1'b0, 32'h0, d); chk("R8", "level view masks low IDs", d, 32'h0010_0000);
        line[5] = 1'b0; line[20] = 1'b0;
        wipe();
        @(negedge clk);
        s_req = 1'b1; s_we = 1'b1; s_sel = 2'd3; s_word = 5'd2; s_wd = 32'h0000_0400;
        @(negedge clk);
        s_req = 1'b0; s_we = 1'b0;
        #1 chk("R8", "level write loads sample", 32'(pend[74]), 32'd1);
        @(negedge clk) #1 chk("R8", "level resampled", 32'(pend[74]), 32'd0);
        s_acc(2'd3, 5'd0, 1'b1, 32'h0000_0008, d);
        chk("R8", "low-ID level write ignored", 32'(pend[3]), 32'd0);
    endtask

    task automatic t_oor();
        logic [31:0] d;
        wipe();
        g_acc(2'd0, 5'd3, 1'b1, 32'hFFFF_FFFF, d);
        chk("R9", "oor write leaves word0", pend[31:0], 32'h0);
        chk("R9", "oor write leaves word2", pend[95:64], 32'h0);
        g_acc(2'd0, 5'd3, 1'b0, 32'h0, d); chk("R9", "oor read zero", d, 32'h0);
        g_acc(2'd2, 5'd0, 1'b0, 32'h0, d); chk("R9", "guest oor status", d, 32'h1);
        s_acc(2'd0, 5'd3, 1'b0, 32'h0, d); chk("R9", "save oor read zero", d, 32'h0);
        g_acc(2'd2, 5'd0, 1'b0, 32'h0, d); chk("R10", "both status bits", d, 32'h3);
        g_acc(2'd2, 5'd0, 1'b1, 32'h1, d);
        g_acc(2'd2, 5'd0, 1'b0, 32'h0, d); chk("R10", "w1c clears bit0", d, 32'h2);
        s_acc(2'd2, 5'd0, 1'b1, 32'hFFFF_FFFD, d);
        s_acc(2'd2, 5'd0, 1'b0, 32'h0, d); chk("R10", "save load status", d, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        line = '0; act = '0;
        trig = {N{1'b1}};
        trig[3] = 1'b0; trig[70] = 1'b0; trig[74] = 1'b0;
        g_req = 1'b0; g_we = 1'b0; g_sel = 2'd0; g_word = '0; g_wd = '0;
        s_req = 1'b0; s_we = 1'b0; s_sel = 2'd0; s_word = '0; s_wd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_edge();
        t_set_prio();
        t_level();
        t_level_drop();
        t_save();
        t_level_view();
        t_oor();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule